// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This unit handles hardware handshaking for a UART with receive and transmit FIFOs of up to 128 bytes. On the receive side it drives the active-low request-to-send pin from the receive FIFO fill count. Two programmable thresholds give it hysteresis: the far end is throttled when the FIFO is nearly full, and it is released only once the FIFO has drained well below that point. On the transmit side it samples the active-low clear-to-send pin through a synchronizer. While the far end withholds permission, it blocks the start of any new character.

Each direction has its own enable bit in an 8-bit enhanced-feature configuration byte. With automatic receive throttling switched off, the pin follows the modem-control RTS bit. The unit never interrupts a character the serializer has already started. It only decides whether the next start request becomes a start. The synchronized clear-to-send state is also output as a status bit for the modem-status register.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While `rst_n` is low, `rts_n` is 1 (deasserted), `msr_cts` is 0, and with `feat_cfg[7]` = 1 `tx_allow` and `tx_start` are 0.
- R2: With automatic RTS enabled (`feat_cfg[6]` = 1), one clock after `rx_level` is at or above the high threshold `thr_hi_cfg[6:0]`, `rts_n` is 1.
- R3: With automatic RTS enabled, one clock after `rx_level` is at or below the low threshold `thr_lo_cfg[6:0]` and below the high threshold, `rts_n` is 0.
- R4: With automatic RTS enabled, a level strictly between the two thresholds keeps `rts_n` at its previous value (hysteresis).
- R5: Bit 7 of both threshold bytes is ignored. Thresholds compare as unsigned 7-bit values against the 8-bit level.
- R6: If the low threshold is not below the high threshold, a level that meets both conditions deasserts RTS. The high threshold has priority.
- R7: With automatic RTS disabled (`feat_cfg[6]` = 0), `rts_n` equals the inverse of `mcr_rts` one clock later.
- R8: `cts_n` passes through two flip-flops. `msr_cts` is the inverse of `cts_n` as sampled two clocks earlier, where 1 means clear to send.
- R9: With automatic CTS enabled (`feat_cfg[7]` = 1), `tx_allow` equals `msr_cts`, and `tx_start` is `tx_req` gated by `tx_allow`.
- R10: With automatic CTS disabled (`feat_cfg[7]` = 0), `tx_allow` is 1 and `tx_start` follows `tx_req` whatever the state of `cts_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | 8 | Receive FIFO byte count (0 to 128) |
| thr_lo_cfg | input | 8 | Low (release) threshold, bits 6:0 used |
| thr_hi_cfg | input | 8 | High (throttle) threshold, bits 6:0 used |
| feat_cfg | input | 8 | Enhanced features: bit 6 automatic RTS, bit 7 automatic CTS |
| mcr_rts | input | 1 | Modem-control RTS bit (1 = assert) |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_req | input | 1 | Serializer requests to start a character |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_allow | output | 1 | A new character may start |
| tx_start | output | 1 | Gated start for the serializer |
| msr_cts | output | 1 | Synchronized CTS status (modem-status bit 4) |

## Verification
The bench builds the unit with its defaults: an 8-bit level, 7-bit thresholds and a two-stage synchronizer. This allows a full 128 count, and it allows a high threshold of 127 so the level can exceed every possible threshold value. Thresholds of 32 and 96 exercise the hysteresis band at and around both edges. Crossed thresholds exercise the priority rule, and bytes with bit 7 set exercise the masking. The two-flop depth gives a visible one-clock gap between a pin change and its effect, and the bench checks on both sides of that gap.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;

    // Registered state of the receive-side throttle
    typedef struct packed {
        logic hold;   // 1 = far end throttled by hysteresis
        logic rts_n;  // registered pin value
    } rts_state_t;

endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic ok
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = pin_n;
        end else begin : g_many
            always_comb sync_d = {sync_q[STAGES-2:0], pin_n};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign ok = ~sync_q[STAGES-1];
endmodule

// File: rtl/rts_hyst.sv
module rts_hyst
    import uart_flow_pkg::*;
#(
    parameter int LVL_W = 8,
    parameter int THR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [THR_W-1:0] thr_lo,
    input  logic [THR_W-1:0] thr_hi,
    input  logic             auto_en,
    input  logic             manual_rts,
    output logic             rts_n
);
    rts_state_t st_d, st_q;
    logic at_hi, at_lo;

    always_comb begin
        at_hi = level >= LVL_W'(thr_hi);
        at_lo = level <= LVL_W'(thr_lo);
        st_d  = st_q;
        if (at_hi)      st_d.hold = 1'b1;
        else if (at_lo) st_d.hold = 1'b0;
        st_d.rts_n = auto_en ? st_d.hold : ~manual_rts;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{hold: 1'b0, rts_n: 1'b1};
        else        st_q <= st_d;
    end

    assign rts_n = st_q.rts_n;
endmodule

// File: rtl/tx_gate.sv
module tx_gate (
    input  logic auto_en,
    input  logic cts_ok,
    input  logic tx_req,
    output logic tx_allow,
    output logic tx_start
);
    always_comb begin
        tx_allow = ~auto_en | cts_ok;
        tx_start = tx_req & tx_allow;
    end
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
    parameter int LVL_W      = 8,
    parameter int THR_W      = 7,
    parameter int CFG_W      = 8,
    parameter int SYNC_DEPTH = 2,
    parameter int RTS_EN_BIT = 6,
    parameter int CTS_EN_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [CFG_W-1:0] thr_lo_cfg,
    input  logic [CFG_W-1:0] thr_hi_cfg,
    input  logic [CFG_W-1:0] feat_cfg,
    input  logic             mcr_rts,
    input  logic             cts_n,
    input  logic             tx_req,
    output logic             rts_n,
    output logic             tx_allow,
    output logic             tx_start,
    output logic             msr_cts
);
    localparam int PAD_W = CFG_W - THR_W;

    logic cts_ok;
    logic unused_cfg_bits;

    assign unused_cfg_bits = ^{thr_lo_cfg[CFG_W-1 -: PAD_W],
                               thr_hi_cfg[CFG_W-1 -: PAD_W], feat_cfg};

    cts_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_n(cts_n), .ok(cts_ok)
    );

    rts_hyst #(.LVL_W(LVL_W), .THR_W(THR_W)) u_rts (
        .clk(clk), .rst_n(rst_n), .level(rx_level),
        .thr_lo(thr_lo_cfg[THR_W-1:0]), .thr_hi(thr_hi_cfg[THR_W-1:0]),
        .auto_en(feat_cfg[RTS_EN_BIT]), .manual_rts(mcr_rts), .rts_n(rts_n)
    );

    tx_gate u_gate (
        .auto_en(feat_cfg[CTS_EN_BIT]), .cts_ok(cts_ok), .tx_req(tx_req),
        .tx_allow(tx_allow), .tx_start(tx_start)
    );

    assign msr_cts = cts_ok;
endmodule

// File: rtl/uart_flow_ctrl_chk.sv
module uart_flow_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rx_level,
    input logic [7:0] thr_lo_cfg,
    input logic [7:0] thr_hi_cfg,
    input logic [7:0] feat_cfg,
    input logic       mcr_rts,
    input logic       cts_n,
    input logic       tx_req,
    input logic       rts_n,
    input logic       tx_allow,
    input logic       tx_start,
    input logic       msr_cts
);
    logic [1:0] age_q;
    logic       hi_hit, lo_hit;

    assign hi_hit = rx_level >= {1'b0, thr_hi_cfg[6:0]};
    assign lo_hit = rx_level <= {1'b0, thr_lo_cfg[6:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R2
    hi_throttle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (feat_cfg[6] && hi_hit) |=> rts_n);

    // R3
    lo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (feat_cfg[6] && lo_hit && !hi_hit) |=> !rts_n);

    // R4
    band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && feat_cfg[6] && $past(feat_cfg[6]) && !lo_hit && !hi_hit)
        |=> $stable(rts_n));

    // R7
    manual_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!feat_cfg[6]) |=> (rts_n == !$past(mcr_rts)));

    // R8
    cts_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (msr_cts == !$past(cts_n, 2)));

    // R9
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && feat_cfg[7]) |-> msr_cts);

    // R10
    cts_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!feat_cfg[7]) |-> (tx_allow && (tx_start == tx_req)));
endmodule

bind uart_flow_ctrl uart_flow_ctrl_chk u_chk (.*);

// File: tb/uart_flow_ctrl_test.sv
module uart_flow_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_level = 8'd0;
    logic [7:0] thr_lo_cfg = 8'd32;
    logic [7:0] thr_hi_cfg = 8'd96;
    logic [7:0] feat_cfg = 8'hC0;
    logic       mcr_rts = 1'b0;
    logic       cts_n = 1'b1;
    logic       tx_req = 1'b1;
    logic       rts_n, tx_allow, tx_start, msr_cts;

    typedef struct {
        string tag;
        logic  rts_n;
        logic  allow;
        logic  start;
        logic  msr;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #10 clk = ~clk;

    uart_flow_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level),
        .thr_lo_cfg(thr_lo_cfg), .thr_hi_cfg(thr_hi_cfg), .feat_cfg(feat_cfg),
        .mcr_rts(mcr_rts), .cts_n(cts_n), .tx_req(tx_req),
        .rts_n(rts_n), .tx_allow(tx_allow), .tx_start(tx_start), .msr_cts(msr_cts)
    );

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if ({rts_n, tx_allow, tx_start, msr_cts} !== {e.rts_n, e.allow, e.start, e.msr}) begin
                    errors++;
                    $display("FAIL %s: got rts_n=%b allow=%b start=%b msr=%b, expected %b %b %b %b",
                             e.tag, rts_n, tx_allow, tx_start, msr_cts,
                             e.rts_n, e.allow, e.start, e.msr);
                end
            end
        end
    end

    // driver side: wait n edges, then expect at the following negedge
    task automatic expect_after(input int n, input string tag, input logic r,
                                input logic a, input logic s, input logic m);
        exp_t e;
        repeat (n) @(posedge clk);
        @(negedge clk);
        e.tag = tag; e.rts_n = r; e.allow = a; e.start = s; e.msr = m;
        exp_q.push_back(e);
        ->sample_ev;
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        expect_after(2, "R1 reset", 1'b1, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        // R3 empty FIFO asserts RTS; CTS still deasserted
        expect_after(1, "R3 level 0", 1'b0, 1'b0, 1'b0, 1'b0);
        rx_level = 8'd95;
        expect_after(1, "R4 level 95 below high", 1'b0, 1'b0, 1'b0, 1'b0);
        rx_level = 8'd96;
        expect_after(1, "R2 level 96 at high", 1'b1, 1'b0, 1'b0, 1'b0);
        rx_level = 8'd50;
        expect_after(1, "R4 level 50 holds throttle", 1'b1, 1'b0, 1'b0, 1'b0);
        rx_level = 8'd33;
        expect_after(1, "R4 level 33 holds throttle", 1'b1, 1'b0, 1'b0, 1'b0);
        rx_level = 8'd32;
        expect_after(1, "R3 level 32 at low", 1'b0, 1'b0, 1'b0, 1'b0);
        rx_level = 8'd60;
        expect_after(1, "R4 level 60 stays asserted", 1'b0, 1'b0, 1'b0, 1'b0);
        // R5 bit 7 of thresholds ignored
        thr_hi_cfg = 8'hE0; thr_lo_cfg = 8'hA0;
        rx_level = 8'd96;
        expect_after(1, "R5 high 0xE0 acts as 96", 1'b1, 1'b0, 1'b0, 1'b0);
        rx_level = 8'd40;
        expect_after(1, "R5 band with masked bytes", 1'b1, 1'b0, 1'b0, 1'b0);
        rx_level = 8'd32;
        expect_after(1, "R5 low 0xA0 acts as 32", 1'b0, 1'b0, 1'b0, 1'b0);
        // R6 crossed thresholds, high wins
        thr_lo_cfg = 8'd50; thr_hi_cfg = 8'd40; rx_level = 8'd45;
        expect_after(1, "R6 crossed thresholds", 1'b1, 1'b0, 1'b0, 1'b0);
        // R2 full FIFO against top threshold
        thr_lo_cfg = 8'd0; thr_hi_cfg = 8'd127; rx_level = 8'd0;
        expect_after(1, "R3 release before full test", 1'b0, 1'b0, 1'b0, 1'b0);
        rx_level = 8'd128;
        expect_after(1, "R2 level 128 over 127", 1'b1, 1'b0, 1'b0, 1'b0);
        // R7 manual mode
        feat_cfg = 8'h80; mcr_rts = 1'b1;
        expect_after(1, "R7 manual assert", 1'b0, 1'b0, 1'b0, 1'b0);
        mcr_rts = 1'b0;
        expect_after(1, "R7 manual deassert", 1'b1, 1'b0, 1'b0, 1'b0);
        // R8/R9 CTS synchronizer and gating
        cts_n = 1'b0;
        expect_after(1, "R8 one flop not yet visible", 1'b1, 1'b0, 1'b0, 1'b0);
        expect_after(1, "R9 start after two flops", 1'b1, 1'b1, 1'b1, 1'b1);
        tx_req = 1'b0;
        expect_after(0, "R9 no request no start", 1'b1, 1'b1, 1'b0, 1'b1);
        tx_req = 1'b1; cts_n = 1'b1;
        expect_after(2, "R9 CTS withdrawn blocks start", 1'b1, 1'b0, 1'b0, 1'b0);
        // R10 CTS bypass
        feat_cfg = 8'h00;
        expect_after(0, "R10 bypass allows start", 1'b1, 1'b1, 1'b1, 1'b0);
        expect_after(1, "R10 bypass with CTS high", 1'b1, 1'b1, 1'b1, 1'b0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule